// File: doc/BRIEF.md
# Paging Control Register and Translation Flush Controller

This block keeps the control registers that steer address translation: a paging control word (index 0), a page table base (index 3) and a paging extension word (index 4). It also stores five general control words at the remaining indices, and it keeps the address-bit-20 gate as a 32-bit mask for the address path. Software-side logic writes a register through a one-cycle write port that carries a register index and a 32-bit value. The gate state arrives on a level input that is sampled every cycle.

Each write is compared against the value it replaces. When the change alters how addresses translate, the block raises a one-cycle flush strobe towards the translation cache. A companion bit says whether every entry must go, or only the non-global ones. A change of the address-bit-20 gate always calls for a full flush. Leaving reset produces one full flush. The block also drives a protected-mode flag and its complement, the segment-base-add flag, from the stored paging control word. A combinational read port returns any stored register.

Top module: `ctrl_reg_flush_ctl`

## Requirements
- R1: While reset is high, index 0 holds 0x60000010 and every other index holds 0. The gate mask is 0xFFFFFFFF, flush_req is 0, prot_mode is 0 and seg_add is 1.
- R2: In the first cycle after reset is released, flush_req is 1 and flush_all is 1 for exactly one cycle.
- R3: A write to index 0 always stores its data. It gives a full flush (flush_req=1, flush_all=1) only when bit 0, bit 16 or bit 31 differs from the stored value.
- R4: A write to index 3 always stores its data. If bit 31 of index 0 is 1, it gives a non-global flush (flush_req=1, flush_all=0). Otherwise it gives no flush.
- R5: A write to index 4 always stores its data. It gives a full flush only when bit 4, bit 5 or bit 7 differs from the stored value.
- R6: A write to index 1, 2, 5, 6 or 7 stores its data and causes no flush.
- R7: The gate mask equals 0xFFEFFFFF with bit 20 set to the stored gate state. When a20_en differs from bit 20 of the mask, the mask is updated and a full flush is given. Holding the same state gives no flush.
- R8: prot_mode equals bit 0 of index 0 and seg_add is its inverse.
- R9: When several flush causes occur in the same cycle, they produce a single flush pulse, and that pulse is full whenever any of the causes is full.
- R10: Stored values, the mask, the flags and the flush strobe all take their new values one clock edge after the write or gate change is sampled. flush_req returns to 0 in any cycle without a cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe for one cycle |
| wr_sel | input | 3 | Index of the register being written |
| wr_data | input | 32 | Value to write |
| a20_en | input | 1 | Address-bit-20 gate level |
| rd_sel | input | 3 | Index for the read port |
| rd_data | output | 32 | Stored value at rd_sel (combinational) |
| flush_req | output | 1 | One-cycle flush strobe |
| flush_all | output | 1 | 1 selects a full flush, 0 selects non-global only; valid with flush_req |
| prot_mode | output | 1 | Protected-mode flag |
| seg_add | output | 1 | Segment-base-add flag |
| a20_mask | output | 32 | Address mask for bit 20 gating |

## Verification
Every registered result is due exactly one edge after its cause: the stored value, the mask, both flags, and the flush strobe with its type bit. The reset flush is due at the first edge at which reset is low. The bench drives stimulus at the falling edge and waits for the next rising edge. It samples half a nanosecond later, and then sweeps rd_sel across all indices before the following falling edge. A bench-side model holds the pre-write values, so each expected flush is computed from the old and new bit patterns before the model is updated.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int XLEN    = 32;
    localparam int REG_CNT = 8;
    localparam int SEL_W   = $clog2(REG_CNT);

    localparam int IDX_PAGING = 0;
    localparam int IDX_BASE   = 3;
    localparam int IDX_EXT    = 4;

    localparam int BIT_PE  = 0;
    localparam int BIT_WP  = 16;
    localparam int BIT_PG  = 31;
    localparam int BIT_PSE = 4;
    localparam int BIT_PAE = 5;
    localparam int BIT_PGE = 7;
    localparam int BIT_GATE = 20;

    localparam logic [XLEN-1:0] PAGING_RESET = 32'h6000_0010;
    localparam logic [XLEN-1:0] PAGING_WATCH =
        (32'h1 << BIT_PE) | (32'h1 << BIT_WP) | (32'h1 << BIT_PG);
    localparam logic [XLEN-1:0] EXT_WATCH =
        (32'h1 << BIT_PSE) | (32'h1 << BIT_PAE) | (32'h1 << BIT_PGE);

    typedef struct packed {
        logic             valid;
        logic [SEL_W-1:0] sel;
        logic [XLEN-1:0]  data;
    } wr_req_t;

    typedef enum logic [1:0] {
        FL_NONE      = 2'd0,
        FL_NONGLOBAL = 2'd1,
        FL_FULL      = 2'd2
    } flush_kind_e;

    typedef struct packed {
        logic req;
        logic all;
    } flush_t;

    function automatic logic [XLEN-1:0] reg_reset(input int idx);
        return (idx == IDX_PAGING) ? PAGING_RESET : '0;
    endfunction

    function automatic logic [XLEN-1:0] gate_mask(input logic en);
        logic [XLEN-1:0] m;
        m = ~(32'h1 << BIT_GATE);
        m[BIT_GATE] = en;
        return m;
    endfunction

    function automatic logic bits_moved(input logic [XLEN-1:0] a,
                                        input logic [XLEN-1:0] b,
                                        input logic [XLEN-1:0] watch);
        return |((a ^ b) & watch);
    endfunction

endpackage

// File: rtl/crf_regfile.sv
module crf_regfile
    import crf_pkg::*;
#(
    parameter int N_REG = REG_CNT,
    parameter int SW    = SEL_W,
    parameter int W     = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       wr,
    input  logic [SW-1:0] rd_sel,
    output logic [W-1:0]  rd_data,
    output logic [W-1:0]  paging_q,
    output logic [W-1:0]  ext_q
);

    logic [N_REG-1:0][W-1:0] regs;

    for (genvar g = 0; g < N_REG; g++) begin : g_entry
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= reg_reset(g);
            end else if (wr.valid && (wr.sel == SW'(g))) begin
                q <= wr.data;
            end
        end
        assign regs[g] = q;
    end

    assign rd_data  = regs[rd_sel];
    assign paging_q = regs[IDX_PAGING];
    assign ext_q    = regs[IDX_EXT];

endmodule

// File: rtl/crf_a20_gate.sv
module crf_a20_gate
    import crf_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         a20_en,
    output logic [W-1:0] mask,
    output logic         changed
);

    assign changed = (a20_en != mask[BIT_GATE]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
        end else if (changed) begin
            mask <= gate_mask(a20_en);
        end
    end

endmodule

// File: rtl/crf_flush_decide.sv
module crf_flush_decide
    import crf_pkg::*;
#(
    parameter int W = XLEN
) (
    input  wr_req_t      wr,
    input  logic [W-1:0] paging_q,
    input  logic [W-1:0] ext_q,
    input  logic         gate_changed,
    input  logic         boot_pend,
    output flush_kind_e  kind
);

    logic full_cause;
    logic ng_cause;
    logic hit_paging, hit_base, hit_ext;

    always_comb begin
        hit_paging = wr.valid && (wr.sel == IDX_PAGING[SEL_W-1:0]);
        hit_base   = wr.valid && (wr.sel == IDX_BASE[SEL_W-1:0]);
        hit_ext    = wr.valid && (wr.sel == IDX_EXT[SEL_W-1:0]);

        full_cause = boot_pend || gate_changed
                   || (hit_paging && bits_moved(wr.data, paging_q, PAGING_WATCH))
                   || (hit_ext    && bits_moved(wr.data, ext_q, EXT_WATCH));
        ng_cause   = hit_base && paging_q[BIT_PG];

        if (full_cause) begin
            kind = FL_FULL;
        end else if (ng_cause) begin
            kind = FL_NONGLOBAL;
        end else begin
            kind = FL_NONE;
        end
    end

endmodule

// File: rtl/ctrl_reg_flush_ctl.sv
module ctrl_reg_flush_ctl
    import crf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             a20_en,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [XLEN-1:0]  rd_data,
    output logic             flush_req,
    output logic             flush_all,
    output logic             prot_mode,
    output logic             seg_add,
    output logic [XLEN-1:0]  a20_mask
);

    wr_req_t         wr;
    logic [XLEN-1:0] paging_q;
    logic [XLEN-1:0] ext_q;
    logic            gate_changed;
    logic            boot_pend;
    flush_kind_e     kind;
    flush_t          flush_q;

    assign wr.valid = wr_valid;
    assign wr.sel   = wr_sel;
    assign wr.data  = wr_data;

    crf_regfile #(
        .N_REG (REG_CNT),
        .SW    (SEL_W),
        .W     (XLEN)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .paging_q (paging_q),
        .ext_q    (ext_q)
    );

    crf_a20_gate #(
        .W (XLEN)
    ) u_gate (
        .clk     (clk),
        .rst     (rst),
        .a20_en  (a20_en),
        .mask    (a20_mask),
        .changed (gate_changed)
    );

    crf_flush_decide #(
        .W (XLEN)
    ) u_decide (
        .wr           (wr),
        .paging_q     (paging_q),
        .ext_q        (ext_q),
        .gate_changed (gate_changed),
        .boot_pend    (boot_pend),
        .kind         (kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_pend <= 1'b1;
            flush_q   <= '0;
        end else begin
            boot_pend   <= 1'b0;
            flush_q.req <= (kind != FL_NONE);
            flush_q.all <= (kind == FL_FULL);
        end
    end

    assign flush_req = flush_q.req;
    assign flush_all = flush_q.all;
    assign prot_mode = paging_q[BIT_PE];
    assign seg_add   = ~paging_q[BIT_PE];

endmodule

// File: rtl/crf_checker.sv
module crf_checker
    import crf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_valid,
    input logic [SEL_W-1:0] wr_sel,
    input logic [XLEN-1:0]  wr_data,
    input logic             a20_en,
    input logic             flush_req,
    input logic             flush_all,
    input logic             prot_mode,
    input logic             seg_add,
    input logic [XLEN-1:0]  a20_mask,
    input logic [XLEN-1:0]  paging_q,
    input logic             boot_pend
);

    logic quiet_gate;
    logic other_idx;
    assign quiet_gate = (a20_en == a20_mask[BIT_GATE]);
    assign other_idx  = (wr_sel != 3'd0) && (wr_sel != 3'd3) && (wr_sel != 3'd4);

    assert_boot_flush_R2: assert property (@(posedge clk) disable iff (rst)
        boot_pend |=> (flush_req && flush_all));

    assert_paging_store_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_sel == 3'd0) |=> (paging_q == $past(wr_data)));

    assert_paging_full_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_sel == 3'd0 && ((wr_data ^ paging_q) & PAGING_WATCH) != '0)
        |=> (flush_req && flush_all));

    assert_base_ng_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_sel == 3'd3 && paging_q[BIT_PG] && quiet_gate && !boot_pend)
        |=> (flush_req && !flush_all));

    assert_base_none_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_sel == 3'd3 && !paging_q[BIT_PG] && quiet_gate && !boot_pend)
        |=> !flush_req);

    assert_other_noflush_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && other_idx && quiet_gate && !boot_pend) |=> !flush_req);

    assert_gate_flush_R7: assert property (@(posedge clk) disable iff (rst)
        !quiet_gate |=> (flush_req && flush_all && a20_mask[BIT_GATE] == $past(a20_en)));

    assert_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_sel == 3'd0) |=> (prot_mode == $past(wr_data[BIT_PE]) && seg_add == !prot_mode));

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid && quiet_gate && !boot_pend) |=> !flush_req);

endmodule

bind ctrl_reg_flush_ctl crf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .a20_en    (a20_en),
    .flush_req (flush_req),
    .flush_all (flush_all),
    .prot_mode (prot_mode),
    .seg_add   (seg_add),
    .a20_mask  (a20_mask),
    .paging_q  (paging_q),
    .boot_pend (boot_pend)
);

// File: tb/tb_ctrl_reg_flush_ctl.sv
`timescale 1ns/100ps
module tb_ctrl_reg_flush_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        a20_en = 1'b1;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        flush_req, flush_all, prot_mode, seg_add;
    logic [31:0] a20_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_reg [8];
    logic [31:0] m_mask;

    always #2 clk = ~clk;

    ctrl_reg_flush_ctl dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_sel(wr_sel),
        .wr_data(wr_data), .a20_en(a20_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .flush_req(flush_req), .flush_all(flush_all), .prot_mode(prot_mode),
        .seg_add(seg_add), .a20_mask(a20_mask)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, got, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #0.1;
            check(tag, $sformatf("reg[%0d]", i), rd_data, m_reg[i]);
        end
    endtask

    // One cycle of stimulus; expectation computed from the model before update.
    task automatic step(input logic v, input logic [2:0] s, input logic [31:0] d,
                        input logic a, input string tag);
        logic full, ng, exp_req, exp_all;
        logic [31:0] wpg, wext;
        wpg  = 32'h8001_0001;
        wext = 32'h0000_00B0;
        @(negedge clk);
        wr_valid = v; wr_sel = s; wr_data = d; a20_en = a;
        full = (a != m_mask[20]);
        if (v && s == 3'd0 && ((d ^ m_reg[0]) & wpg) != 0) full = 1'b1;
        if (v && s == 3'd4 && ((d ^ m_reg[4]) & wext) != 0) full = 1'b1;
        ng = v && s == 3'd3 && m_reg[0][31];
        exp_req = full | ng;
        exp_all = full;
        if (v) m_reg[s] = d;
        m_mask = 32'hFFEF_FFFF | ({31'b0, a} << 20);
        @(posedge clk);
        #0.5;
        check(tag, "flush_req", {31'b0, flush_req}, {31'b0, exp_req});
        if (exp_req) check(tag, "flush_all", {31'b0, flush_all}, {31'b0, exp_all});
        check(tag, "a20_mask", a20_mask, m_mask);
        check("R8", "prot_mode", {31'b0, prot_mode}, {31'b0, m_reg[0][0]});
        check("R8", "seg_add", {31'b0, seg_add}, {31'b0, ~m_reg[0][0]});
        check_regs(tag);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 8; i++) m_reg[i] = (i == 0) ? 32'h6000_0010 : 32'h0;
        m_mask = 32'hFFFF_FFFF;

        // R1: reset state
        repeat (3) @(posedge clk);
        #0.5;
        check("R1", "flush_req", {31'b0, flush_req}, 32'h0);
        check("R1", "a20_mask", a20_mask, 32'hFFFF_FFFF);
        check("R1", "prot_mode", {31'b0, prot_mode}, 32'h0);
        check("R1", "seg_add", {31'b0, seg_add}, 32'h1);
        check_regs("R1");

        // R2: single full flush after release
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #0.5;
        check("R2", "flush_req", {31'b0, flush_req}, 32'h1);
        check("R2", "flush_all", {31'b0, flush_all}, 32'h1);
        @(posedge clk);
        #0.5;
        check("R2", "flush_req second cycle", {31'b0, flush_req}, 32'h0);

        // R10: idle cycles give nothing
        step(1'b0, 3'd0, 32'h0, 1'b1, "R10");

        // R3: sweep of the three watched bits plus unwatched bits
        for (int k = 0; k < 24; k++) begin
            int p;
            p = (k * 5 + k / 8) % 8;
            d = 32'h1357_9BDF * k;
            d[0] = p[0]; d[16] = p[1]; d[31] = p[2];
            step(1'b1, 3'd0, d, 1'b1, "R3");
        end
        d = m_reg[0] ^ 32'h0F0F_0F00 ^ 32'h0000_0002;
        step(1'b1, 3'd0, d, 1'b1, "R3");

        // R4: base writes with paging on and off
        step(1'b1, 3'd0, 32'h8000_0001, 1'b1, "R4");
        for (int k = 0; k < 4; k++) step(1'b1, 3'd3, 32'h0012_3000 + 32'(k) * 32'h1000, 1'b1, "R4");
        step(1'b1, 3'd0, 32'h0000_0001, 1'b1, "R4");
        for (int k = 0; k < 4; k++) step(1'b1, 3'd3, 32'hABC0_0000 + 32'(k), 1'b1, "R4");

        // R5: all transitions of the three watched extension bits
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                d = 32'h0000_0000;
                d[4] = a[0]; d[5] = a[1]; d[7] = a[2];
                step(1'b1, 3'd4, d, 1'b1, "R5");
                d = 32'h0000_0648;
                d[4] = b[0]; d[5] = b[1]; d[7] = b[2];
                step(1'b1, 3'd4, d, 1'b1, "R5");
            end
        end

        // R6: general indices store without flush
        for (int s = 0; s < 8; s++) begin
            if (s != 0 && s != 3 && s != 4) begin
                step(1'b1, 3'(s), 32'hFFFF_FFFF, 1'b1, "R6");
                step(1'b1, 3'(s), 32'h8001_00B1 + 32'(s), 1'b1, "R6");
            end
        end

        // R7: gate toggles and holds
        step(1'b0, 3'd0, 32'h0, 1'b0, "R7");
        step(1'b0, 3'd0, 32'h0, 1'b0, "R7");
        step(1'b0, 3'd0, 32'h0, 1'b1, "R7");
        step(1'b0, 3'd0, 32'h0, 1'b1, "R7");
        step(1'b0, 3'd0, 32'h0, 1'b0, "R7");

        // R9: merged causes
        step(1'b1, 3'd0, 32'h8000_0000, 1'b1, "R9");
        step(1'b1, 3'd3, 32'h0045_6000, 1'b0, "R9");
        step(1'b1, 3'd0, 32'h8000_0000, 1'b1, "R9");
        step(1'b1, 3'd4, 32'h0000_0080, 1'b0, "R9");
        step(1'b1, 3'd3, 32'h0077_7000, 1'b0, "R9");
        step(1'b0, 3'd0, 32'h0, 1'b0, "R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule